// File: doc/BRIEF.md
# Serial NAND Bring-Up Sequencer

This block brings a serial NAND flash device to a usable state after power-up, with no processor involved. A one-cycle `start` pulse launches a fixed series of SPI frames through a byte-transfer handshake. The first frame resets the device. The block then polls the device status until the busy flag clears. It reads the two identification bytes and turns the capacity field into a count of erase blocks. Last, it turns on the device's internal ECC and removes all block write protection. Each of those two configuration writes is enclosed by a write-enable frame before it and a write-disable frame after it.

The SPI shifter sits outside this block. For every byte the sequencer raises `xfer_req` and presents the byte on `xfer_tx`. The shifter answers with a one-cycle `xfer_ack` and, in that same cycle, puts the byte it received on `xfer_rx`. Chip select stays low for the whole of each frame. The wait between two status polls comes from the `poll_gap` input, so no software timer is needed. When the sequence ends, either `done` rises together with the decoded block count, or `unknown_dev` rises and the block sends no further frames.

Top module: `spinand_bringup`

## Requirements
- R1: While reset is held, and after it is released, `cs_n` is 1, `xfer_req` is 0, and `done`, `unknown_dev` and `blk_count` are all 0.
- R2: A `start` pulse sends frames in this fixed order. Reset {FF}. One or more status polls. ID read {9F 00 00 00}. Write-enable {06}. ECC-on write {1F B0 10}. Write-disable {04}. One or more status polls. Write-enable {06}. Unprotect write {1F A0 00}. Write-disable {04}.
- R3: A status poll is the three bytes {0F C0 00}. The byte received with the third byte is the status. If status bit 0 is 1, the poll is repeated. Bits 7..1 of the status have no effect.
- R4: Before a repeated poll, `cs_n` stays high for exactly `poll_gap`+2 cycles. Between any other two frames it stays high for exactly one cycle.
- R5: The byte received with the third byte of the ID frame is the manufacturer code. If it is not C8, `unknown_dev` rises and no frame follows the ID frame.
- R6: The low nibble of the byte received with the fourth byte of the ID frame sets the capacity: 1 gives 1024, 2 gives 2048 and 4 gives 4096. The high nibble is ignored. Any other low-nibble value raises `unknown_dev` and no frame follows the ID frame.
- R7: `done` rises only after the final write-disable frame. `done` and `unknown_dev` are never high together. Both stay high until the next `start`. `blk_count` is 0 whenever `unknown_dev` is high.
- R8: `xfer_req` holds, and `xfer_tx` stays stable, until `xfer_ack` arrives. `cs_n` is low whenever `xfer_req` is high. Each `xfer_ack` consumes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts the sequence; ignored while a sequence is running |
| poll_gap | input | GAP_W | Extra idle cycles between busy polls |
| cs_n | output | 1 | Device select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | One-cycle byte-complete strobe |
| xfer_rx | input | 8 | Byte received, valid while `xfer_ack` is high |
| done | output | 1 | Sequence completed with a recognised device |
| unknown_dev | output | 1 | Device not recognised |
| blk_count | output | BLK_W | Decoded number of erase blocks |

## Verification
The assertions assume that the shifter raises `xfer_ack` only while `xfer_req` is high and holds it for a single cycle. They also assume that `poll_gap` stays constant during a sequence. The bench's flash model follows both rules. It answers each requested byte after a random wait of zero to two cycles, and it changes `poll_gap` only between sequences. The randomised parts of the stimulus are the manufacturer and device bytes, the number of busy polls after reset and after the configuration write, and the upper status bits. The directed cases add every valid capacity, a device byte with its high nibble set, and each rejection path.

// File: rtl/spinand_bringup.sv
module spinand_bringup #(
  parameter int GAP_W = 16,
  parameter int BLK_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] poll_gap,
  output logic             cs_n,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx,
  output logic             done,
  output logic             unknown_dev,
  output logic [BLK_W-1:0] blk_count
);

  localparam logic [3:0] F_ID   = 4'd2;
  localparam logic [3:0] F_LAST = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP, S_WAIT} st_t;

  st_t              st;
  logic [3:0]       fr;
  logic [1:0]       bi;
  logic             busy_bit;
  logic [7:0]       mfr;
  logic [3:0]       cap;
  logic [GAP_W-1:0] cnt;

  function automatic logic [7:0] fbyte(input logic [3:0] f, input logic [1:0] b);
    case (f)
      4'd0:       fbyte = 8'hFF;
      4'd1, 4'd6: fbyte = (b == 2'd0) ? 8'h0F : (b == 2'd1) ? 8'hC0 : 8'h00;
      4'd2:       fbyte = (b == 2'd0) ? 8'h9F : 8'h00;
      4'd3, 4'd7: fbyte = 8'h06;
      4'd4:       fbyte = (b == 2'd0) ? 8'h1F : (b == 2'd1) ? 8'hB0 : 8'h10;
      4'd8:       fbyte = (b == 2'd0) ? 8'h1F : (b == 2'd1) ? 8'hA0 : 8'h00;
      default:    fbyte = 8'h04;
    endcase
  endfunction

  function automatic logic [1:0] lastb(input logic [3:0] f);
    case (f)
      4'd1, 4'd4, 4'd6, 4'd8: lastb = 2'd2;
      4'd2:                   lastb = 2'd3;
      default:                lastb = 2'd0;
    endcase
  endfunction

  wire is_poll = (fr == 4'd1) || (fr == 4'd6);
  wire cap_ok  = (cap == 4'd1) || (cap == 4'd2) || (cap == 4'd4);
  wire id_ok   = (mfr == 8'hC8) && cap_ok;
  wire [BLK_W-1:0] blk_dec = (cap == 4'd1) ? BLK_W'(1024) :
                             (cap == 4'd2) ? BLK_W'(2048) : BLK_W'(4096);

  assign cs_n     = (st != S_FRAME);
  assign xfer_req = (st == S_FRAME);
  assign xfer_tx  = fbyte(fr, bi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      fr          <= '0;
      bi          <= '0;
      busy_bit    <= 1'b0;
      mfr         <= '0;
      cap         <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      unknown_dev <= 1'b0;
      blk_count   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st          <= S_FRAME;
          fr          <= '0;
          bi          <= '0;
          done        <= 1'b0;
          unknown_dev <= 1'b0;
          blk_count   <= '0;
        end
        S_FRAME: if (xfer_ack) begin
          if (is_poll && bi == 2'd2) busy_bit <= xfer_rx[0];
          if (fr == F_ID && bi == 2'd2) mfr <= xfer_rx;
          if (fr == F_ID && bi == 2'd3) cap <= xfer_rx[3:0];
          if (bi == lastb(fr)) st <= S_GAP;
          else bi <= bi + 2'd1;
        end
        S_GAP: begin
          bi <= '0;
          if (is_poll && busy_bit) begin
            st  <= S_WAIT;
            cnt <= poll_gap;
          end else if (fr == F_ID && !id_ok) begin
            st          <= S_IDLE;
            unknown_dev <= 1'b1;
          end else if (fr == F_LAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_FRAME;
            fr <= fr + 4'd1;
            if (fr == F_ID) blk_count <= blk_dec;
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= S_FRAME;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !cs_n);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && unknown_dev));

  // R6
  blk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blk_count == BLK_W'(1024) || blk_count == BLK_W'(2048) ||
              blk_count == BLK_W'(4096)));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_dev |-> (cs_n && blk_count == '0));

endmodule

// File: tb/spinand_bringup_tb_top.sv
module spinand_bringup_tb_top;
  localparam int GAP_W = 16;
  localparam int BLK_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [GAP_W-1:0] poll_gap = '0;
  logic cs_n, xfer_req, done, unknown_dev;
  logic [7:0] xfer_tx;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rx = 8'h00;
  logic [BLK_W-1:0] blk_count;

  always #10 clk = ~clk;

  spinand_bringup #(.GAP_W(GAP_W), .BLK_W(BLK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_gap(poll_gap),
    .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .done(done),
    .unknown_dev(unknown_dev), .blk_count(blk_count));

  int total = 0;
  int bad = 0;

  logic [7:0] sc_mfr, sc_dev;
  int nb1, nb2;

  logic [31:0] flog [0:63];
  int flen [0:63];
  int fgap [0:63];
  int nfr = 0;
  logic [7:0] cur [0:3];
  int pos = 0, lat = 0, hi_run = 0, busy_left = 0;
  bit infr = 0;

  logic [31:0] ew [0:63];
  int el [0:63];
  int ne;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] respond(input logic [7:0] op, input int p);
    logic [7:0] r;
    r = 8'($urandom);
    if (op == 8'h0F && p == 2) begin
      if (busy_left > 0) begin
        busy_left--;
        r[0] = 1'b1;
      end else r[0] = 1'b0;
    end else if (op == 8'h9F && p == 2) r = sc_mfr;
    else if (op == 8'h9F && p == 3) r = sc_dev;
    return r;
  endfunction

  // flash model: answers bytes and logs frames
  initial begin
    forever begin
      @(negedge clk);
      xfer_ack = 1'b0;
      if (cs_n) begin
        if (infr) begin
          if (nfr < 64) begin
            flog[nfr] = {cur[0], cur[1], cur[2], cur[3]};
            flen[nfr] = pos;
          end
          if (cur[0] == 8'hFF) busy_left = nb1;
          if (cur[0] == 8'h1F) busy_left = nb2;
          nfr++;
          infr = 0;
          pos = 0;
          for (int k = 0; k < 4; k++) cur[k] = 8'h00;
          hi_run = 1;
        end else hi_run++;
      end else begin
        if (!infr) begin
          infr = 1;
          if (nfr < 64) fgap[nfr] = hi_run;
        end
        if (xfer_req) begin
          if (lat > 0) lat--;
          else if (pos < 4) begin
            cur[pos] = xfer_tx;
            xfer_rx = respond(cur[0], pos);
            xfer_ack = 1'b1;
            pos++;
            lat = int'($urandom % 3);
          end
        end
      end
    end
  end

  function automatic bit dev_ok(input logic [7:0] m, input logic [7:0] d);
    return m == 8'hC8 && (d[3:0] == 4'd1 || d[3:0] == 4'd2 || d[3:0] == 4'd4);
  endfunction

  function automatic int exp_blk(input logic [7:0] m, input logic [7:0] d);
    if (!dev_ok(m, d)) return 0;
    return (d[3:0] == 4'd1) ? 1024 : (d[3:0] == 4'd2) ? 2048 : 4096;
  endfunction

  task automatic add(input logic [31:0] w, input int l);
    ew[ne] = w;
    el[ne] = l;
    ne++;
  endtask

  task automatic run_case(input logic [7:0] m, input logic [7:0] d,
                          input int b1, input int b2, input int pg);
    bit ok;
    int w;
    sc_mfr = m; sc_dev = d; nb1 = b1; nb2 = b2;
    poll_gap = GAP_W'(pg);
    @(negedge clk);
    nfr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || unknown_dev) && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (20) @(negedge clk);
    ok = dev_ok(m, d);
    ne = 0;
    add(32'hFF000000, 1);
    for (int i = 0; i <= b1; i++) add(32'h0FC00000, 3);
    add(32'h9F000000, 4);
    if (ok) begin
      add(32'h06000000, 1);
      add(32'h1FB01000, 3);
      add(32'h04000000, 1);
      for (int i = 0; i <= b2; i++) add(32'h0FC00000, 3);
      add(32'h06000000, 1);
      add(32'h1FA00000, 3);
      add(32'h04000000, 1);
    end
    // R7 completion flags
    chk(done == ok, "R7 done", done, ok);
    // R5 R6 rejection flag
    chk(unknown_dev == !ok, "R5/R6 unknown_dev", unknown_dev, !ok);
    // R6 decoded count
    chk(int'(blk_count) == exp_blk(m, d), "R6 blk_count", blk_count, exp_blk(m, d));
    // R2 R5 frame count, no traffic after end
    chk(nfr == ne, "R2 frame count", nfr, ne);
    for (int i = 0; i < ne && i < nfr; i++) begin
      // R2 R3 R8 frame bytes
      chk(flog[i] == ew[i] && flen[i] == el[i], "R2/R3/R8 frame",
          {flog[i], 8'(flen[i])}, {ew[i], 8'(el[i])});
      if (i > 0) begin
        int eg;
        eg = (ew[i-1] == 32'h0FC00000 && ew[i] == 32'h0FC00000) ? pg + 2 : 1;
        // R4 select gap
        chk(fgap[i] == eg, "R4 gap", fgap[i], eg);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int k = 0; k < 4; k++) cur[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n && !xfer_req && !done && !unknown_dev && blk_count == 0,
        "R1 in reset", {cs_n, xfer_req, done, unknown_dev}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after reset
    chk(cs_n && !xfer_req && !done && !unknown_dev && blk_count == 0,
        "R1 after reset", {cs_n, xfer_req, done, unknown_dev}, 4'b1000);

    run_case(8'hC8, 8'h01, 0, 0, 0);
    run_case(8'hC8, 8'h02, 2, 1, 3);
    run_case(8'hC8, 8'h04, 1, 3, 5);
    run_case(8'hC8, 8'hF2, 0, 2, 1);
    run_case(8'hC9, 8'h01, 1, 0, 2);
    run_case(8'hC8, 8'h03, 0, 0, 0);
    run_case(8'hC8, 8'h00, 2, 0, 4);
    run_case(8'hC8, 8'h08, 0, 0, 0);
    for (int n = 0; n < 12; n++) begin
      logic [7:0] m, d;
      m = ($urandom % 10 < 7) ? 8'hC8 : 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 4 != 0) d[3:0] = 4'(1 << ($urandom % 3));
      run_case(m, d, int'($urandom % 5), int'($urandom % 5), int'($urandom % 8));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule